// File: doc/BRIEF.md
# Host Parallel Command, Status and Sample Interface

This block sits between a microcontroller's asynchronous parallel bus and the audio core of a record/playback engine. The host drives chip select, active-low read and write strobes, a data/command select line and a 16-bit data bus. When the select line is high, an access moves one audio sample. A write puts the sample into a one-slot holding stage toward the sample FIFO. A read returns the FIFO head and pops it. When the select line is low, an access uses only the low byte. A write there loads an 8-bit command, and a read returns a status byte.

All bus pins are sampled into the core clock domain through a synchroniser chain. An access is taken on the rising edge of its strobe. The address phase (chip select, select line and data) is taken from the cycle just before that edge. The sample path toward the FIFO is valid/ready. The write side holds a sample with `wr_valid` until `wr_ready` is seen. The read side pops only when the FIFO reports `rd_valid`. Read data is combinational from the raw pins, so the host sees it within the strobe.

The block also drives the FIFO flag pins with programmable polarity and an active-low busy pin that covers record, playback and pause. It presents the configuration fields (mode, rate, FIFO size, DMA enable, volume, bus width) to the rest of the engine.

Top module: `hb_host_if`

## Requirements
- R1: While `cs_n` is high, strobe pulses cause no FIFO push or pop and no configuration change, and the low byte of the bus is not driven.
- R2: Each low pulse of `wr_n` or `rd_n` makes exactly one access, taken after its rising edge. The select line, chip select and data are taken from the sample just before that edge.
- R3: A write with `dc`=1 offers a sample on `wr_data`. In 16-bit mode this is the full bus word. In 8-bit mode (the reset state) it is `bus_in[7:0]` with the upper byte zero.
- R4: A read with `dc`=1 drives the FIFO head `rd_data` on the bus while the strobe is low. It raises `rd_pop` for exactly one cycle after the rising edge, and only if `rd_valid` is high; otherwise nothing is popped.
- R5: Write back-pressure: `wr_valid` stays high with `wr_data` stable until `wr_ready` is high at a clock edge. A sample write that arrives while the slot is occupied is dropped.
- R6: `bus_oe[0]` is high only while `cs_n` and `rd_n` are both low. `bus_oe[1]` additionally needs `dc`=1 and 16-bit mode, except as R10 allows.
- R7: A command byte is opcode `bus_in[7:4]` and operand `bus_in[3:0]`; `bus_in[15:8]` is ignored. The opcodes are:
  - 1: mode ← operand[3:0]
  - 2: rate ← operand[3:0]
  - 3: FIFO size ← operand[1:0]
  - 4: flag inversion {full, mid, empty} ← operand[2:0]
  - 5: DMA enable ← operand[0]
  - 6: volume ← operand[2:0]
  - 7: 16-bit width ← operand[0], upper-byte output port ← operand[1]

  All fields reset to zero.
- R8: Opcodes 0 and 8 to 15 change no configuration field.
- R9: A read with `dc`=0 returns a status byte on `bus_out[7:0]`: bit 7 is activity (record, play or pause), bit 6 is full, bit 5 is mid, bit 4 is empty, and bits 3:0 are the mode. In this read the upper byte is undriven unless R10 applies.
- R10: In 8-bit mode with the upper-byte output port set, `bus_oe[1]` is high at all times and `bus_out[15:8]` carries `xmem_byte`.
- R11: `busy_n` is low while any of `rec_on`, `play_on` or `pause_on` is high, and high otherwise.
- R12: `flag_empty`, `flag_mid` and `flag_full` equal the FIFO flags, each inverted when its inversion bit is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| dc | input | 1 | 1 = sample data phase, 0 = command/status phase |
| bus_in | input | 16 | Bus value driven by the host |
| bus_out | output | 16 | Bus value driven by the block |
| bus_oe | output | 2 | Output enable per byte (bit 0 low byte, bit 1 high byte) |
| xmem_byte | input | 8 | Byte driven on the upper lines when they serve as an output port |
| wr_data | output | 16 | Sample toward the FIFO |
| wr_valid | output | 1 | Sample offered |
| wr_ready | input | 1 | FIFO accepts the sample |
| rd_data | input | 16 | FIFO head sample |
| rd_valid | input | 1 | FIFO holds a sample |
| rd_pop | output | 1 | Consume the FIFO head |
| fifo_empty | input | 1 | FIFO empty flag |
| fifo_mid | input | 1 | FIFO over half full |
| fifo_full | input | 1 | FIFO full |
| flag_empty | output | 1 | Empty flag pin, programmable polarity |
| flag_mid | output | 1 | Mid flag pin, programmable polarity |
| flag_full | output | 1 | Full flag pin, programmable polarity |
| rec_on | input | 1 | Recording active |
| play_on | input | 1 | Playback active |
| pause_on | input | 1 | Paused |
| busy_n | output | 1 | Low while active |
| cfg_mode | output | 4 | Operating mode |
| cfg_rate | output | 4 | Sampling rate selector |
| cfg_fsize | output | 2 | FIFO size selector |
| cfg_dma | output | 1 | DMA enable |
| cfg_vol | output | 3 | Volume step |
| cfg_wide | output | 1 | 1 = 16-bit bus |

## Verification
The bench strobes with chip select high and looks for stray pushes, pops, configuration loads or low-byte drive. A design that ignores chip select would fail all of these.

It writes a second sample while the holding slot is blocked. A design without back-pressure would overwrite or duplicate the first sample, and the scoreboard would see the wrong order or count.

It reads while the FIFO reports nothing available, which catches a design that pops blindly. It also counts pops per strobe pulse, which catches level-triggered access.

Unknown opcodes, upper-byte garbage on commands, 8-bit versus 16-bit sample width, and the upper-byte output port are each checked at the pins. These catch a wrong field decode or a wrongly driven upper byte.

// File: rtl/hb_pkg.sv
package hb_pkg;
  localparam int BUS_W  = 16;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic              cs_n;
    logic              wr_n;
    logic              rd_n;
    logic              dc;
    logic [BUS_W-1:0]  data;
  } pinset_t;

  typedef struct packed {
    logic [3:0] mode;
    logic [3:0] rate;
    logic [1:0] fsize;
    logic [2:0] flag_inv;
    logic       dma;
    logic [2:0] vol;
    logic       wide;
    logic       xport;
  } cfg_t;

  typedef enum logic [3:0] {
    OP_MODE  = 4'h1,
    OP_RATE  = 4'h2,
    OP_FSIZE = 4'h3,
    OP_POL   = 4'h4,
    OP_DMA   = 4'h5,
    OP_VOL   = 4'h6,
    OP_WIDTH = 4'h7
  } opcode_e;
endpackage

// File: rtl/hb_sync.sv
module hb_sync #(
  parameter int W      = 20,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hb_strobe.sv
module hb_strobe
  import hb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  pinset_t          cur,
  output logic             cmd_we,
  output logic             dat_we,
  output logic             dat_re,
  output logic [BUS_W-1:0] cap
);
  pinset_t prev;
  logic    wr_rise, rd_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= '1;
    else        prev <= cur;
  end

  // an access is the low-to-high step of a strobe that was seen low with chip select low
  assign wr_rise = cur.wr_n & ~prev.wr_n & ~prev.cs_n;
  assign rd_rise = cur.rd_n & ~prev.rd_n & ~prev.cs_n;
  assign cmd_we  = wr_rise & ~prev.dc;
  assign dat_we  = wr_rise &  prev.dc;
  assign dat_re  = rd_rise &  prev.dc;
  assign cap     = prev.data;

  // R2: an access needs a fresh rising edge, so events never repeat on consecutive cycles
  a_r2_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we | dat_we) |=> !(cmd_we | dat_we));
endmodule

// File: rtl/hb_cfg.sv
module hb_cfg
  import hb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_we,
  input  logic [BYTE_W-1:0] cmd,
  output cfg_t             cfg
);
  logic [3:0] op, arg;
  assign op  = cmd[7:4];
  assign arg = cmd[3:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cmd_we) begin
      case (op)
        OP_MODE:  cfg.mode     <= arg;
        OP_RATE:  cfg.rate     <= arg;
        OP_FSIZE: cfg.fsize    <= arg[1:0];
        OP_POL:   cfg.flag_inv <= arg[2:0];
        OP_DMA:   cfg.dma      <= arg[0];
        OP_VOL:   cfg.vol      <= arg[2:0];
        OP_WIDTH: begin
          cfg.wide  <= arg[0];
          cfg.xport <= arg[1];
        end
        default: ;
      endcase
    end
  end

  // R8: opcodes outside 1..7 leave every field alone
  a_r8_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && (op == 4'h0 || op[3])) |=> $stable(cfg));
endmodule

// File: rtl/hb_datapath.sv
module hb_datapath
  import hb_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dat_we,
  input  logic             dat_re,
  input  logic [BUS_W-1:0] cap,
  input  logic             wide,
  output logic [BUS_W-1:0] wr_data,
  output logic             wr_valid,
  input  logic             wr_ready,
  input  logic             rd_valid,
  output logic             rd_pop
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_data  <= '0;
    end else if (wr_valid) begin
      if (wr_ready) wr_valid <= 1'b0;
    end else if (dat_we) begin
      wr_valid <= 1'b1;
      wr_data  <= wide ? cap : {{(BUS_W-BYTE_W){1'b0}}, cap[BYTE_W-1:0]};
    end
  end

  assign rd_pop = dat_re & rd_valid;

  // R5: an offered sample waits unchanged for the FIFO
  a_r5_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_data)));
  // R4: one pop per strobe pulse
  a_r4_single_pop: assert property (@(posedge clk) disable iff (!rst_n)
    rd_pop |=> !rd_pop);
endmodule

// File: rtl/hb_host_if.sv
module hb_host_if
  import hb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cs_n,
  input  logic        wr_n,
  input  logic        rd_n,
  input  logic        dc,
  input  logic [15:0] bus_in,
  output logic [15:0] bus_out,
  output logic [1:0]  bus_oe,
  input  logic [7:0]  xmem_byte,
  output logic [15:0] wr_data,
  output logic        wr_valid,
  input  logic        wr_ready,
  input  logic [15:0] rd_data,
  input  logic        rd_valid,
  output logic        rd_pop,
  input  logic        fifo_empty,
  input  logic        fifo_mid,
  input  logic        fifo_full,
  output logic        flag_empty,
  output logic        flag_mid,
  output logic        flag_full,
  input  logic        rec_on,
  input  logic        play_on,
  input  logic        pause_on,
  output logic        busy_n,
  output logic [3:0]  cfg_mode,
  output logic [3:0]  cfg_rate,
  output logic [1:0]  cfg_fsize,
  output logic        cfg_dma,
  output logic [2:0]  cfg_vol,
  output logic        cfg_wide
);
  localparam int PW = $bits(pinset_t);

  pinset_t          raw, synced;
  logic             cmd_we, dat_we, dat_re;
  logic [BUS_W-1:0] cap;
  cfg_t             cfg;
  logic             active, rd_sel, upper_port;
  logic [2:0]       flags_raw, flags_pin;

  assign raw = '{cs_n: cs_n, wr_n: wr_n, rd_n: rd_n, dc: dc, data: bus_in};

  hb_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(raw), .q(synced));

  hb_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .cur(synced),
    .cmd_we(cmd_we), .dat_we(dat_we), .dat_re(dat_re), .cap(cap));

  hb_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd(cap[BYTE_W-1:0]), .cfg(cfg));

  hb_datapath u_dp (
    .clk(clk), .rst_n(rst_n), .dat_we(dat_we), .dat_re(dat_re), .cap(cap),
    .wide(cfg.wide), .wr_data(wr_data), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_pop(rd_pop));

  // host-facing read path works straight from the pins
  assign active     = rec_on | play_on | pause_on;
  assign busy_n     = ~active;
  assign rd_sel     = ~cs_n & ~rd_n;
  assign upper_port = ~cfg.wide & cfg.xport;

  assign bus_oe[0]     = rd_sel;
  assign bus_oe[1]     = (rd_sel & dc & cfg.wide) | upper_port;
  assign bus_out[7:0]  = dc ? rd_data[7:0]
                            : {active, fifo_full, fifo_mid, fifo_empty, cfg.mode};
  assign bus_out[15:8] = upper_port ? xmem_byte : (dc ? rd_data[15:8] : 8'h00);

  assign flags_raw = {fifo_full, fifo_mid, fifo_empty};
  for (genvar g = 0; g < 3; g++) begin : g_flag
    assign flags_pin[g] = flags_raw[g] ^ cfg.flag_inv[g];
  end
  assign flag_empty = flags_pin[0];
  assign flag_mid   = flags_pin[1];
  assign flag_full  = flags_pin[2];

  assign cfg_mode  = cfg.mode;
  assign cfg_rate  = cfg.rate;
  assign cfg_fsize = cfg.fsize;
  assign cfg_dma   = cfg.dma;
  assign cfg_vol   = cfg.vol;
  assign cfg_wide  = cfg.wide;

  // R6: the low byte is only driven during a selected read
  a_r6_low_oe_selected: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe[0] |-> (!cs_n && !rd_n));
  // R10: narrow bus without the port leaves the upper lines as inputs
  a_r10_upper_input: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_wide && !cfg.xport) |-> !bus_oe[1]);
  // R1: with chip select high for the last two samples, no sample push starts
  a_r1_no_push_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (synced.cs_n && $past(synced.cs_n) && !wr_valid) |=> !wr_valid);
endmodule

// File: tb/test_hb_host_if.sv
module test_hb_host_if;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, wr_n = 1'b1, rd_n = 1'b1, dc = 1'b0;
  logic [15:0] bus_in = '0, rd_data = '0;
  logic [7:0]  xmem_byte = 8'h5A;
  logic wr_ready = 1'b1, rd_valid = 1'b0;
  logic fifo_empty = 1'b0, fifo_mid = 1'b0, fifo_full = 1'b0;
  logic rec_on = 1'b0, play_on = 1'b0, pause_on = 1'b0;
  logic [15:0] bus_out, wr_data;
  logic [1:0]  bus_oe;
  logic wr_valid, rd_pop, flag_empty, flag_mid, flag_full, busy_n;
  logic [3:0] cfg_mode, cfg_rate;
  logic [1:0] cfg_fsize;
  logic cfg_dma, cfg_wide;
  logic [2:0] cfg_vol;

  int checks = 0, errors = 0, xfers = 0, pops = 0;
  logic [15:0] exp_q[$];

  always #5 clk = ~clk;

  hb_host_if i_hb_host_if (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  // scoreboard monitor: pops expected samples as the FIFO side takes them
  always @(negedge clk) begin
    if (rst_n) begin
      if (wr_valid && wr_ready) begin
        xfers++;
        checks++;
        if (exp_q.size() == 0) begin
          errors++;
          $display("FAIL R5: actual=%h expected=none (unexpected sample)", wr_data);
        end else begin
          logic [15:0] e;
          e = exp_q.pop_front();
          if (wr_data !== e) begin
            errors++;
            $display("FAIL R3: actual=%h expected=%h", wr_data, e);
          end
        end
      end
      if (rd_pop) pops++;
    end
  end

  task automatic bus_write(input logic sel, input logic dcv, input logic [15:0] v);
    cs_n = ~sel; dc = dcv; bus_in = v;
    step(1); wr_n = 1'b0;
    step(3); wr_n = 1'b1;
    step(3); cs_n = 1'b1;
    step(4);
  endtask

  task automatic bus_read(input logic sel, input logic dcv,
                          output logic [15:0] val, output logic [1:0] oe);
    cs_n = ~sel; dc = dcv;
    step(1); rd_n = 1'b0;
    step(2); val = bus_out; oe = bus_oe;
    step(1); rd_n = 1'b1;
    step(3); cs_n = 1'b1;
    step(4);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] v;
    logic [1:0]  oe;
    int n0;
    step(3); rst_n = 1'b1; step(2);

    // reset state
    check("R6 reset oe", bus_oe, 0);
    check("R5 reset valid", wr_valid, 0);
    check("R7 reset cfg", {cfg_mode, cfg_rate, cfg_fsize, cfg_dma, cfg_vol, cfg_wide}, 0);
    check("R11 idle busy", busy_n, 1);

    // R7: each opcode, upper byte carrying garbage that must be ignored
    bus_write(1, 0, 16'hFF15); check("R7 mode", cfg_mode, 4'h5);
    bus_write(1, 0, 16'hAA29); check("R7 rate", cfg_rate, 4'h9);
    bus_write(1, 0, 16'h0032); check("R7 fsize", cfg_fsize, 2'd2);
    bus_write(1, 0, 16'h0051); check("R7 dma", cfg_dma, 1);
    bus_write(1, 0, 16'h0066); check("R7 vol", cfg_vol, 3'd6);

    // R8: unknown opcodes
    bus_write(1, 0, 16'h009F);
    bus_write(1, 0, 16'h0003);
    check("R8 unknown ignored", {cfg_mode, cfg_rate, cfg_fsize, cfg_dma, cfg_vol, cfg_wide},
          {4'h5, 4'h9, 2'd2, 1'b1, 3'd6, 1'b0});

    // R1: chip select high
    bus_write(0, 0, 16'h001A); check("R1 cmd ignored", cfg_mode, 4'h5);
    bus_write(0, 1, 16'h7777); check("R1 no push", xfers, 0);
    rd_valid = 1'b1; rd_data = 16'h1357;
    bus_read(0, 1, v, oe);
    check("R1 no drive", oe, 2'b00);
    check("R1 no pop", pops, 0);

    // R3: narrow then wide sample writes
    exp_q.push_back(16'h00CD); bus_write(1, 1, 16'hABCD);
    check("R3 narrow push", xfers, 1);
    bus_write(1, 0, 16'h0071); check("R10 wide set", cfg_wide, 1);
    exp_q.push_back(16'h1234); bus_write(1, 1, 16'h1234);
    check("R3 wide push", xfers, 2);

    // R5: back-pressure with an overrun write
    wr_ready = 1'b0;
    exp_q.push_back(16'h1111); bus_write(1, 1, 16'h1111);
    bus_write(1, 1, 16'h2222);
    check("R5 held valid", wr_valid, 1);
    check("R5 held data", wr_data, 16'h1111);
    wr_ready = 1'b1; step(4);
    check("R5 one transfer", xfers, 3);
    check("R5 queue drained", exp_q.size(), 0);

    // R4 / R2: sample read in wide mode
    rd_data = 16'hBEEF; n0 = pops;
    bus_read(1, 1, v, oe);
    check("R4 read data", v, 16'hBEEF);
    check("R6 wide oe", oe, 2'b11);
    check("R2 single pop", pops, n0 + 1);
    check("R6 released", bus_oe, 2'b00);
    rd_valid = 1'b0;
    bus_read(1, 1, v, oe);
    check("R4 no pop when empty", pops, n0 + 1);

    // R9 / R11: status byte
    rec_on = 1'b1; fifo_full = 1'b1; step(1);
    check("R11 busy active", busy_n, 0);
    bus_read(1, 0, v, oe);
    check("R9 status", v, 16'h00C5);
    check("R9 status oe", oe, 2'b01);
    rec_on = 1'b0; pause_on = 1'b1; step(1);
    check("R11 pause busy", busy_n, 0);
    pause_on = 1'b0; step(1);
    check("R11 idle again", busy_n, 1);

    // R12: flag polarity
    fifo_empty = 1'b1; fifo_mid = 1'b1; step(1);
    check("R12 plain flags", {flag_full, flag_mid, flag_empty}, 3'b111);
    bus_write(1, 0, 16'h0045); fifo_mid = 1'b0; step(1);
    check("R12 inverted flags", {flag_full, flag_mid, flag_empty}, 3'b000);

    // R10: upper byte output port in narrow mode
    bus_write(1, 0, 16'h0072); step(1);
    check("R10 port oe", bus_oe, 2'b10);
    check("R10 port data", bus_out[15:8], 8'h5A);
    bus_write(1, 0, 16'h0070); step(1);
    check("R10 port off", bus_oe, 2'b00);
    rd_valid = 1'b1; rd_data = 16'hC3A5;
    bus_read(1, 1, v, oe);
    check("R10 narrow read oe", oe, 2'b01);
    check("R4 narrow read data", v[7:0], 8'hA5);

    step(5);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule